// File: doc/BRIEF.md
# Offset Calibration Sequencer

This block sits in the digital back end of a two-channel audio converter, after decimation. While its active-low reset is held low, the whole path is idle and drives only zeros. On the first clock edge after reset is released, the block starts a single calibration cycle and raises a busy flag for the whole of that cycle. During calibration it averages a fixed, power-of-two number of strobed samples per channel into an offset estimate. A steering output tells the analog front end to present the common-mode voltage as the measurement source. When calibration is done, the block subtracts the stored offset from every sample and saturates the result. A first-order DC-blocking high-pass stage can be switched in on the corrected samples.

The measurement source is chosen by a select pin, which is sampled once at the edge that starts calibration. While busy, output strobes still pass through so that downstream timing does not change, but they carry zero data. After calibration, each output follows its input strobe by one clock.

Top module: `offset_cal_seq`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the next cycle shows `cal_busy`, `tap_vcm` and `out_valid` low and both output samples zero.
- R2: At the first rising edge where `rst_n` is high after being low, calibration starts, and `cal_busy` reads high in the following cycle.
- R3: `cal_busy` stays high until exactly 2^CAL_LOG2 strobed samples have been accepted. It falls at the edge that accepts the last one. Cycles without a strobe do not advance the count.
- R4: `ref_sel` is captured at the edge that starts calibration. `tap_vcm` is high throughout calibration when the captured value is 0 (measure common mode) and low when it is 1 (measure live inputs). Later changes of `ref_sel` have no effect.
- R5: Each channel's offset is the sum of its calibration samples shifted arithmetically right by CAL_LOG2, which rounds toward minus infinity.
- R6: After calibration, with the filter off, each strobed sample x produces `out_valid` high and output x − offset one cycle later.
- R7: The corrected value saturates to the range −8388608 … 8388607 of 24-bit two's complement.
- R8: Every strobe accepted while calibrating produces `out_valid` high with both outputs zero.
- R9: With `hpf_en` high, the output is y = c − c_prev + y_prev − (y_prev >>> HPF_SHIFT), where c is the corrected sample. The result saturates to 24 bits and is kept as y_prev.
- R10: With `hpf_en` low, the output equals c. The filter memory is then loaded with c_prev = c and y_prev = 0, so the first filtered sample after enabling is c − c_prev.
- R11: A cycle without `smp_valid` leaves `out_valid` low in the next cycle and both output samples unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; low holds the path idle |
| smp_valid | input | 1 | One-cycle strobe marking a new sample pair |
| in_left | input | 24 | Left sample, signed two's complement |
| in_right | input | 24 | Right sample, signed two's complement |
| ref_sel | input | 1 | Calibration source: 0 common mode, 1 live inputs |
| hpf_en | input | 1 | 1 switches the DC-blocking filter in |
| cal_busy | output | 1 | High while calibration is in progress |
| tap_vcm | output | 1 | High while the front end must present the common-mode voltage |
| out_valid | output | 1 | Strobe for the output pair |
| out_left | output | 24 | Corrected left sample |
| out_right | output | 24 | Corrected right sample |

## Verification
The bench builds the block with CAL_LOG2 = 4 and HPF_SHIFT = 4. With 16-sample calibrations, the bench can run two full calibrations in a few dozen cycles. One of them averages extreme codes, so both saturation limits can be reached after it. A right-channel average of −12.5 checks that the offset rounds toward minus infinity. The short filter shift makes each step of the decay large enough to tell a wrong feedback term from a correct one within twenty samples.

// File: rtl/offcal_pkg.sv
package offcal_pkg;

    localparam int SMP_W = 24;
    localparam int NCH   = 2;
    localparam int EXT_W = SMP_W + 2;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic signed [EXT_W-1:0] ext_t;

    typedef enum logic [1:0] {
        SEQ_OFF = 2'd0,
        SEQ_CAL = 2'd1,
        SEQ_RUN = 2'd2
    } seq_e;

    localparam ext_t SMP_MAX = ext_t'((1 <<< (SMP_W - 1)) - 1);
    localparam ext_t SMP_MIN = -ext_t'(1 <<< (SMP_W - 1));

    // clamp a widened value into the sample range
    function automatic smp_t clamp_smp(input ext_t v);
        if (v > SMP_MAX)
            return smp_t'(SMP_MAX);
        else if (v < SMP_MIN)
            return smp_t'(SMP_MIN);
        else
            return smp_t'(v);
    endfunction

endpackage

// File: rtl/ocal_ctrl.sv
module ocal_ctrl
    import offcal_pkg::*;
#(
    parameter int CAL_LOG2 = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    input  logic ref_sel,
    output seq_e state_o,
    output logic cal_last,
    output logic tap_vcm
);

    localparam logic [CAL_LOG2-1:0] LAST_IDX = {CAL_LOG2{1'b1}};

    seq_e                state;
    logic [CAL_LOG2-1:0] cnt;
    logic                src_live;

    assign cal_last = (state == SEQ_CAL) && smp_valid && (cnt == LAST_IDX);
    assign tap_vcm  = (state == SEQ_CAL) && !src_live;
    assign state_o  = state;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_OFF;
            cnt      <= '0;
            src_live <= 1'b0;
        end else begin
            unique case (state)
                SEQ_OFF: begin
                    state    <= SEQ_CAL;
                    cnt      <= '0;
                    src_live <= ref_sel;
                end
                SEQ_CAL: begin
                    if (smp_valid) begin
                        cnt <= cnt + 1'b1;
                    end
                    if (cal_last) begin
                        state <= SEQ_RUN;
                    end
                end
                SEQ_RUN: state <= SEQ_RUN;
                default: state <= SEQ_OFF;
            endcase
        end
    end

endmodule

// File: rtl/ocal_accum.sv
module ocal_accum
    import offcal_pkg::*;
#(
    parameter int CAL_LOG2 = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_en,
    input  logic done,
    input  smp_t smp_i,
    output smp_t offset_o
);

    localparam int ACC_W = SMP_W + CAL_LOG2;

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] sum_next;

    assign sum_next = acc + ACC_W'(smp_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= '0;
            offset_o <= '0;
        end else if (acc_en) begin
            acc <= sum_next;
            if (done) begin
                offset_o <= smp_t'(sum_next >>> CAL_LOG2);
            end
        end
    end

endmodule

// File: rtl/ocal_dcblk.sv
module ocal_dcblk
    import offcal_pkg::*;
#(
    parameter int HPF_SHIFT = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic busy,
    input  logic smp_valid,
    input  logic hpf_en,
    input  smp_t corr_i,
    output smp_t out_o
);

    smp_t x_prev;
    smp_t y_prev;
    ext_t diff;
    ext_t fb;
    smp_t y_new;

    always_comb begin
        diff  = ext_t'(corr_i) - ext_t'(x_prev);
        fb    = ext_t'(y_prev) - ext_t'(y_prev >>> HPF_SHIFT);
        y_new = clamp_smp(diff + fb);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_prev <= '0;
            y_prev <= '0;
            out_o  <= '0;
        end else if (smp_valid) begin
            if (run) begin
                x_prev <= corr_i;
                if (hpf_en) begin
                    y_prev <= y_new;
                    out_o  <= y_new;
                end else begin
                    y_prev <= '0;
                    out_o  <= corr_i;
                end
            end else if (busy) begin
                out_o <= '0;
            end
        end
    end

endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq
    import offcal_pkg::*;
#(
    parameter int CAL_LOG2  = 10,
    parameter int HPF_SHIFT = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] in_left,
    input  logic [SMP_W-1:0] in_right,
    input  logic             ref_sel,
    input  logic             hpf_en,
    output logic             cal_busy,
    output logic             tap_vcm,
    output logic             out_valid,
    output logic [SMP_W-1:0] out_left,
    output logic [SMP_W-1:0] out_right
);

    seq_e state;
    logic cal_last;
    logic busy;
    logic run;
    smp_t smp_in  [NCH];
    smp_t smp_out [NCH];

    assign smp_in[0] = smp_t'(in_left);
    assign smp_in[1] = smp_t'(in_right);

    ocal_ctrl #(
        .CAL_LOG2 (CAL_LOG2)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .ref_sel   (ref_sel),
        .state_o   (state),
        .cal_last  (cal_last),
        .tap_vcm   (tap_vcm)
    );

    assign busy     = (state == SEQ_CAL);
    assign run      = (state == SEQ_RUN);
    assign cal_busy = busy;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        smp_t off;
        smp_t corr;

        ocal_accum #(
            .CAL_LOG2 (CAL_LOG2)
        ) u_acc (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc_en   (busy && smp_valid),
            .done     (cal_last),
            .smp_i    (smp_in[ch]),
            .offset_o (off)
        );

        assign corr = clamp_smp(ext_t'(smp_in[ch]) - ext_t'(off));

        ocal_dcblk #(
            .HPF_SHIFT (HPF_SHIFT)
        ) u_hpf (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run),
            .busy      (busy),
            .smp_valid (smp_valid),
            .hpf_en    (hpf_en),
            .corr_i    (corr),
            .out_o     (smp_out[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= smp_valid && (state != SEQ_OFF);
        end
    end

    assign out_left  = smp_out[0];
    assign out_right = smp_out[1];

endmodule

// File: rtl/offset_cal_seq_chk.sv
module offset_cal_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        smp_valid,
    input logic        ref_sel,
    input logic        cal_busy,
    input logic        tap_vcm,
    input logic        out_valid,
    input logic [23:0] out_left,
    input logic [23:0] out_right
);

    // R1
    idle_in_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!cal_busy && !tap_vcm && !out_valid && out_left == '0 && out_right == '0));

    // R2
    cal_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && rst_n) |=> cal_busy);

    // R3
    end_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_busy) |-> $past(smp_valid));

    // R3
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cal_busy) && $past(out_valid)) |-> !cal_busy);

    // R4
    tap_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap_vcm |-> cal_busy);

    // R4
    tap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && $past(cal_busy)) |-> $stable(tap_vcm));

    // R8
    zero_while_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cal_busy)) |-> (out_left == '0 && out_right == '0));

    // R11
    hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));

endmodule

bind offset_cal_seq offset_cal_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .ref_sel   (ref_sel),
    .cal_busy  (cal_busy),
    .tap_vcm   (tap_vcm),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right)
);

// File: tb/offset_cal_seq_bench.sv
module offset_cal_seq_bench;

    localparam int CL  = 4;
    localparam int HS  = 4;
    localparam int NCAL = 1 << CL;
    localparam int MAXV = 8388607;
    localparam int MINV = -8388608;

    typedef struct packed {
        logic signed [23:0] il;
        logic signed [23:0] ir;
        logic signed [23:0] el;
        logic signed [23:0] er;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{il: 24'sd15,       ir: -24'sd13,      el: 24'sd0,        er: 24'sd0},
        '{il: 24'sd100,      ir: 24'sd100,      el: 24'sd85,       er: 24'sd113},
        '{il: -24'sd100,     ir: -24'sd100,     el: -24'sd115,     er: -24'sd87},
        '{il: 24'sd8388607,  ir: -24'sd8388608, el: 24'sd8388592,  er: -24'sd8388595},
        '{il: -24'sd8388608, ir: 24'sd8388607,  el: -24'sd8388608, er: 24'sd8388607}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [23:0] in_left = '0;
    logic [23:0] in_right = '0;
    logic        ref_sel = 1'b0;
    logic        hpf_en = 1'b0;
    logic        cal_busy;
    logic        tap_vcm;
    logic        out_valid;
    logic [23:0] out_left;
    logic [23:0] out_right;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    offset_cal_seq #(
        .CAL_LOG2  (CL),
        .HPF_SHIFT (HS)
    ) u_offset_cal_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .in_left   (in_left),
        .in_right  (in_right),
        .ref_sel   (ref_sel),
        .hpf_en    (hpf_en),
        .cal_busy  (cal_busy),
        .tap_vcm   (tap_vcm),
        .out_valid (out_valid),
        .out_left  (out_left),
        .out_right (out_right)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sx(input logic [23:0] v);
        return int'($signed(v));
    endfunction

    task automatic push(input int l, input int r);
        smp_valid = 1'b1;
        in_left   = 24'(l);
        in_right  = 24'(r);
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check_reset_state(input string tag);
        check({tag, " busy"}, int'(cal_busy), 0);
        check({tag, " tap"}, int'(tap_vcm), 0);
        check({tag, " valid"}, int'(out_valid), 0);
        check({tag, " left"}, sx(out_left), 0);
        check({tag, " right"}, sx(out_right), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cp;
        int yp;
        int y;

        // R1: reset holds the block idle
        idle(3);
        check_reset_state("R1");

        // R2, R4: release with common-mode source selected
        ref_sel = 1'b0;
        rst_n   = 1'b1;
        idle(1);
        check("R2 busy after release", int'(cal_busy), 1);
        check("R4 tap for common mode", int'(tap_vcm), 1);

        // R3, R5, R8: first calibration, left 2*i, right -5-i
        for (int i = 0; i < NCAL; i++) begin
            push(2 * i, -5 - i);
            check("R8 valid during cal", int'(out_valid), 1);
            check("R8 zero left during cal", sx(out_left), 0);
            check("R8 zero right during cal", sx(out_right), 0);
            if (i == NCAL / 2) begin
                idle(1);
                check("R3 no strobe keeps busy", int'(cal_busy), 1);
            end
            check("R3 busy length", int'(cal_busy), (i == NCAL - 1) ? 0 : 1);
        end
        check("R4 tap off after cal", int'(tap_vcm), 0);

        // R5, R6, R7: vector table, filter bypassed
        for (int k = 0; k < NVEC; k++) begin
            push(int'(VECS[k].il), int'(VECS[k].ir));
            check("R6 valid", int'(out_valid), 1);
            check("R5 R6 R7 left", sx(out_left), int'(VECS[k].el));
            check("R5 R6 R7 right", sx(out_right), int'(VECS[k].er));
        end

        // R9: step response of the DC blocker
        push(15, -13);
        hpf_en = 1'b1;
        cp = 0;
        yp = 0;
        for (int k = 0; k < 20; k++) begin
            push(1015, -13);
            y  = 1000 - cp + yp - (yp >>> HS);
            cp = 1000;
            yp = y;
            check("R9 filtered left", sx(out_left), y);
            check("R9 filtered right", sx(out_right), 0);
        end

        // R10: bypass then re-enable restarts from c - c_prev
        hpf_en = 1'b0;
        push(1015, 87);
        check("R10 bypass left", sx(out_left), 1000);
        check("R10 bypass right", sx(out_right), 100);
        hpf_en = 1'b1;
        push(1515, 87);
        check("R10 reenable left", sx(out_left), 500);
        check("R10 reenable right", sx(out_right), 0);

        // R11: no strobe leaves outputs alone
        in_left = 24'(-4000);
        idle(1);
        check("R11 valid low", int'(out_valid), 0);
        check("R11 left held", sx(out_left), 500);

        // R1: second reset
        hpf_en = 1'b0;
        rst_n  = 1'b0;
        idle(3);
        check_reset_state("R1 second");

        // R4: live-input source, select changes ignored
        ref_sel = 1'b1;
        rst_n   = 1'b1;
        idle(1);
        check("R2 busy second release", int'(cal_busy), 1);
        check("R4 tap for live inputs", int'(tap_vcm), 0);
        ref_sel = 1'b0;
        for (int i = 0; i < NCAL; i++) begin
            push(MINV, MAXV);
            if (i < NCAL - 1) begin
                check("R4 tap ignores select", int'(tap_vcm), 0);
            end
        end
        check("R3 busy second end", int'(cal_busy), 0);

        // R7: saturation at both limits
        push(MAXV, MINV);
        check("R7 left clips high", sx(out_left), MAXV);
        check("R7 right clips low", sx(out_right), MINV);
        push(0, 0);
        check("R5 R6 left min offset", sx(out_left), MAXV);
        check("R5 R6 right max offset", sx(out_right), -MAXV);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule